// File: doc/BRIEF.md
# Cascadable Two-Wire Serial EEPROM Slave

This block models a byte-wide nonvolatile memory that sits on a two-wire serial bus as a slave. The block samples the bus clock and data lines with a fast system clock and pulls the data line low through an output-enable. It holds 2048 bytes, split into eight blocks of 256 bytes. A control byte picks the device, the block and the transfer direction. Writes collect in a 16-byte page latch. After the STOP, the latch contents go into the array during one self-timed programming cycle.

While the programming cycle runs, the slave ignores all bus traffic. A master finds out that the cycle is complete by repeating the control byte until the slave acknowledges it. Three strap inputs can replace the fixed family code in the control byte, so up to eight devices can share one bus. A write-protect input turns the whole array into read-only storage. With that input held active, the block behaves as a serial ROM.

The serial bus paces all data. The slave never stretches the clock, so this block has no valid/ready stream interface. Its edge has only the two bus lines and the plain strap and protect pins.

Top module: `i2c_ee_top`

## Requirements
- R1: Control byte layout is bits 7..4 device code, bits 3..1 block number, bit 0 direction (1 = read). The device code must be 1010. When the parameter CS_EN is 1, the device code must instead be {1, strap[2:0]}. A control byte that does not match gets no ACK, and the slave stays silent until the next START.
- R2: A START is the data line falling while SCL is high, and a STOP is the data line rising while SCL is high. The slave drives ACK low during the ninth SCL pulse of each byte it accepts. sda_oe changes only while SCL is low.
- R3: A byte write has four parts: the write control byte, an address byte, one data byte and a STOP. After the programming cycle, the data is stored at {block, address byte}.
- R4: Write data fills a 16-byte page latch. The low 4 address bits advance after each byte and wrap inside the page, while the upper bits stay fixed. A 17th and later byte overwrites the earlier latch entry at that offset.
- R5: A STOP that ends a write carrying at least one data byte starts a programming cycle of exactly TWR_CYC system clocks. During that cycle, control bytes get no ACK and sda_oe stays low. Array writes happen only inside the cycle.
- R6: While wp_i is high at the STOP, write data is still acknowledged, but nothing is committed and no programming cycle starts. The next control byte is acknowledged at once.
- R7: A random read works as follows. A write control byte and an address byte set the pointer. A repeated START then comes with a read control byte, and the slave returns the byte at that address.
- R8: A current-address read returns the byte after the last one read. The block number comes from the read control byte.
- R9: A sequential read continues while the master sends ACK. The address increments through all 2048 bytes and rolls over from 2047 to 0. A master NACK ends the read.
- R10: The bus works at SCL rates of 100 kHz and 400 kHz with a 50 MHz system clock.
- R11: After reset, sda_oe is low and no programming cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device address straps, used when CS_EN is 1 |
| wp_i | input | 1 | Write protect, high blocks all array updates |

## Verification
The assertions assume a well-behaved master. Each SCL phase lasts many system clocks, the data line changes only while SCL is low except to form a START or STOP, and no START or STOP arrives while the slave drives the line. Under these assumptions, output-enable changes always follow a synchronised SCL fall. The stimulus keeps to them because the behavioural master steps the bus in quarter-period slices. It moves the data line one quarter after each SCL fall and samples it in the middle of the high phase. At 100 kHz and 400 kHz, each quarter-period slice is at least 31 system clocks.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDR,
    S_WDATA,
    S_RDATA
  } ee_st_e;

  localparam logic [3:0] EE_FAMILY = 4'b1010;
endpackage

// File: rtl/ee_bus_sense.sv
module ee_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_m, sda_m, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; sda_m <= 1'b1;
      scl_s <= 1'b1; sda_s <= 1'b1;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; sda_m <= sda_i;
      scl_s <= scl_m; sda_s <= sda_m;
      scl_d <= scl_s; sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ee_page_commit.sv
module ee_page_commit #(
  parameter int PAGE    = 16,
  parameter int AW      = 11,
  parameter int TWR_CYC = 100000,
  localparam int PW = $clog2(PAGE),
  localparam int TW = $clog2(TWR_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [PW-1:0]    ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             clr,
  input  logic             go,
  input  logic [AW-PW-1:0] go_page,
  output logic             busy,
  output logic             pending,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [7:0]       mem_wdata
);
  localparam logic [TW-1:0] PAGE_T = TW'(PAGE);
  localparam logic [TW-1:0] LAST_T = TW'(TWR_CYC - 1);

  logic [7:0]       slot [PAGE];
  logic [PAGE-1:0]  valid;
  logic [TW-1:0]    tcnt;
  logic [AW-PW-1:0] page_q;

  always_ff @(posedge clk) begin
    if (ld_en && !busy) slot[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      valid  <= '0;
      tcnt   <= '0;
      page_q <= '0;
    end else if (busy) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == LAST_T) begin
        busy  <= 1'b0;
        valid <= '0;
      end
    end else if (go) begin
      busy   <= 1'b1;
      tcnt   <= '0;
      page_q <= go_page;
    end else if (clr) begin
      valid <= '0;
    end else if (ld_en) begin
      valid[ld_idx] <= 1'b1;
    end
  end

  assign pending   = |valid;
  assign mem_we    = busy && (tcnt < PAGE_T) && valid[tcnt[PW-1:0]];
  assign mem_waddr = {page_q, tcnt[PW-1:0]};
  assign mem_wdata = slot[tcnt[PW-1:0]];
endmodule

// File: rtl/i2c_ee_top.sv
module i2c_ee_top
  import ee_pkg::*;
#(
  parameter int BLOCKS      = 8,
  parameter int BLOCK_BYTES = 256,
  parameter int PAGE        = 16,
  parameter int TWR_CYC     = 100000,
  parameter bit CS_EN       = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       wp_i
);
  localparam int DEPTH = BLOCKS * BLOCK_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(PAGE);
  localparam int BW    = $clog2(BLOCKS);
  localparam int WW    = $clog2(BLOCK_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic busy, pending, mem_we, go, clr, ld_en, byte_done, ctrl_hit;
  logic [AW-1:0] mem_waddr, ptr;
  logic [7:0]    mem_wdata, rd_data, sh;
  logic [3:0]    cnt;
  logic          in_ack;
  ee_st_e        st;

  ee_bus_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  ee_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_data)
  );

  assign byte_done = scl_fall && !in_ack && (cnt == 4'd8);
  assign ld_en     = (st == S_WDATA) && byte_done && !busy;
  assign go        = stop_c && pending && !wp_i && !busy;
  assign clr       = !busy && (start_c || (stop_c && !go));
  assign ctrl_hit  = sh[7:4] == (CS_EN ? {1'b1, strap} : EE_FAMILY);

  ee_page_commit #(.PAGE(PAGE), .AW(AW), .TWR_CYC(TWR_CYC)) u_commit (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ptr[PW-1:0]),
    .ld_data(sh), .clr(clr), .go(go), .go_page(ptr[AW-1:PW]),
    .busy(busy), .pending(pending), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; in_ack <= 1'b0;
      sh <= '0; ptr <= '0; sda_oe <= 1'b0;
    end else if (busy) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_CTRL; cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (st == S_RDATA) begin
      if (scl_rise) begin
        if (cnt != 4'd8) cnt <= cnt + 1'b1;
        else if (!in_ack) begin
          if (sda_s) st <= S_IDLE;
          else in_ack <= 1'b1;
        end
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0; cnt <= '0;
          sh <= rd_data; sda_oe <= ~rd_data[7]; ptr <= ptr + 1'b1;
        end else if (cnt == 4'd8) begin
          sda_oe <= 1'b0;
        end else if (cnt != 4'd0) begin
          sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
        end
      end
    end else if (st != S_IDLE) begin
      if (scl_rise && !in_ack && cnt != 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 1'b1;
      end
      if (scl_fall && in_ack) begin
        in_ack <= 1'b0; sda_oe <= 1'b0; cnt <= '0;
        if (st == S_CTRL) begin
          if (sh[0]) begin
            st <= S_RDATA; sh <= rd_data;
            sda_oe <= ~rd_data[7]; ptr <= ptr + 1'b1;
          end else st <= S_ADDR;
        end else if (st == S_ADDR) st <= S_WDATA;
      end else if (byte_done) begin
        in_ack <= 1'b1;
        case (st)
          S_CTRL: begin
            if (ctrl_hit) begin
              sda_oe <= 1'b1;
              ptr[AW-1 -: BW] <= sh[BW:1];
            end else st <= S_IDLE;
          end
          S_ADDR: begin
            sda_oe <= 1'b1;
            ptr[WW-1:0] <= sh;
          end
          S_WDATA: begin
            sda_oe <= 1'b1;
            ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ee_chk.sv
module ee_chk #(
  parameter int TWR_CYC = 100000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic wp_i,
  input logic mem_we
);
  logic [31:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (!busy) bcnt <= '0;
    else bcnt <= bcnt + 1'b1;
  end

  // R2
  oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R5
  quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5
  twr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 32'(TWR_CYC)));

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));
endmodule

bind i2c_ee_top ee_chk #(.TWR_CYC(TWR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .busy(busy), .wp_i(wp_i), .mem_we(mem_we)
);

// File: tb/i2c_ee_top_test.sv
`timescale 1ns/1ps
module i2c_ee_top_test;
  localparam int TWR = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b010;
  logic sda_oe;
  wire  sda_line;

  assign sda_line = ~(m_low | sda_oe);

  always #10 clk = ~clk;

  i2c_ee_top #(.TWR_CYC(TWR), .CS_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap(strap), .wp_i(wp)
  );

  int checks = 0;
  int fails = 0;
  int q = 31;
  bit done = 1'b0;
  logic [7:0] ref_mem [2048];
  logic [7:0] wbuf [32];

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; hold(q);
    scl = 1'b1;   hold(q);
    m_low = 1'b1; hold(q);
    scl = 1'b0;   hold(q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hold(q);
    scl = 1'b1;   hold(q);
    m_low = 1'b0; hold(q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hold(q);
      scl = 1'b1;    hold(2 * q);
      scl = 1'b0;    hold(q);
    end
    m_low = 1'b0; hold(q);
    scl = 1'b1;   hold(q);
    ack = ~sda_line;
    hold(q);
    scl = 1'b0;   hold(q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hold(q);
      scl = 1'b1; hold(q);
      b[i] = sda_line;
      hold(q);
      scl = 1'b0;
    end
    hold(q);
    m_low = give_ack; hold(q);
    scl = 1'b1;       hold(2 * q);
    scl = 1'b0;       hold(q);
    m_low = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input int blk, input bit rd);
    return {4'hA, 3'(blk), rd};
  endfunction

  // write wbuf[0..n-1] starting at block/address; ref follows page wrap (R4)
  task automatic do_write(input int blk, input int a, input int n, input string req);
    bit ack;
    bus_start();
    send_byte(ctrl(blk, 1'b0), ack); check({req, " ctrl ack"}, ack, 1);
    send_byte(8'(a), ack);           check({req, " addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      check({req, " data ack"}, ack, 1);
      if (!wp) ref_mem[blk * 256 + (a & 8'hF0) + ((a + k) & 15)] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic poll_wait(output int nacks);
    bit ack;
    nacks = 0;
    for (int t = 0; t < 40; t++) begin
      bus_start();
      send_byte(ctrl(0, 1'b0), ack);
      bus_stop();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic do_rand_read(input int blk, input int a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(ctrl(blk, 1'b0), ack); check({req, " ctrl ack"}, ack, 1);
    send_byte(8'(a), ack);           check({req, " addr ack"}, ack, 1);
    bus_start();
    send_byte(ctrl(blk, 1'b1), ack); check({req, " read ctrl ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      check({req, " read data"}, b, ref_mem[(blk * 256 + a + k) & 2047]);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check("R11 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    hold(10);
    check("R11 oe after reset", sda_oe, 0);
  endtask

  task automatic t_byte_slow();
    int n;
    q = 125;
    wbuf[0] = 8'hA5;
    do_write(1, 8'h23, 1, "R3 R10");
    poll_wait(n);
    do_rand_read(1, 8'h23, 1, "R7 R10");
    q = 31;
  endtask

  task automatic t_poll();
    int n;
    wbuf[0] = 8'h5C;
    do_write(3, 8'h40, 1, "R5");
    poll_wait(n);
    check("R5 poll saw busy nack", int'(n >= 1), 1);
    check("R5 poll finished", int'(n < 40), 1);
    do_rand_read(3, 8'h40, 1, "R5 R3");
  endtask

  task automatic t_page();
    int n;
    for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h10 + k);
    do_write(2, 8'h3E, 18, "R4");
    poll_wait(n);
    do_rand_read(2, 8'h30, 16, "R4 R9");
  endtask

  task automatic t_current();
    bit ack;
    logic [7:0] b;
    do_rand_read(2, 8'h31, 1, "R7");
    bus_start();
    send_byte(ctrl(2, 1'b1), ack); check("R8 ctrl ack", ack, 1);
    recv_byte(1'b0, b);
    check("R8 current read", b, ref_mem[12'h232]);
    bus_stop();
  endtask

  task automatic t_wp();
    int n;
    wp = 1'b1;
    wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
    do_write(2, 8'h30, 2, "R6");
    poll_wait(n);
    check("R6 no write cycle", n, 0);
    wp = 1'b0;
    do_rand_read(2, 8'h30, 2, "R6 unchanged");
  endtask

  task automatic t_roll();
    int n;
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    do_write(7, 8'hFE, 2, "R9 setup");
    poll_wait(n);
    wbuf[0] = 8'h99;
    do_write(0, 8'h00, 1, "R9 setup");
    poll_wait(n);
    do_rand_read(7, 8'hFE, 3, "R9 rollover");
  endtask

  task automatic t_strap();
    bit ack;
    strap = 3'b011;
    hold(5);
    bus_start();
    send_byte(8'hA4, ack); check("R1 family mismatch nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hB4, ack); check("R1 strap match ack", ack, 1);
    bus_stop();
    strap = 3'b010;
    hold(5);
    bus_start();
    send_byte(8'hC4, ack); check("R1 wrong code nack", ack, 0);
    bus_stop();
  endtask

  initial begin
    hold(20);
    t_reset();
    t_byte_slow();
    t_poll();
    t_page();
    t_current();
    t_wp();
    t_roll();
    t_strap();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule